// File: doc/BRIEF.md
# Serial Frame Transmitter with Break Generation

This block serialises data words onto a single transmit line. A word written into a one-entry holding register is moved into a shift register when the line is free, and is sent as a frame: one low start bit, eight or nine data positions sent least significant bit first, and one high stop bit. When parity is turned on, the last data position carries a parity bit in place of the data word's top bit, so the frame length depends only on the word-length setting. Bit timing comes from a clock divider set by a divisor input. The divider produces an oversampling tick every `divisor + 1` clock cycles, and each bit lasts 16 ticks.

The transmitter starts a frame only while both the global enable and the transmitter enable are high. Word length, parity enable and parity sense are sampled when a frame starts, so changing them mid-frame affects only later frames. Dropping either enable mid-frame lets the current frame finish, after which the line stays high. A break request sends a frame that holds the line low through the start bit and every data position and then high for the stop bit. The request flag clears itself once that stop bit begins.

Two status flags report progress. The first says the holding register is empty and may take a new word. The second says transmission is complete. Each flag has its own enable into a single interrupt output.

Top module: `uart_break_tx`

## Requirements
- R1: A data frame is bit 0 low (start), then data bits LSB first at frame positions 1..N, then one high stop bit; N is 8 when `wordNine`=0 and 9 when `wordNine`=1.
- R2: Every bit lasts exactly 16*(`divisor`+1) clock cycles.
- R3: With `parityEn`=1 the parity bit replaces the data MSB at frame position N; with `parityOdd`=0 the count of ones over the N data positions (including parity) is even, with `parityOdd`=1 it is odd.
- R4: `wordNine`, `parityEn` and `parityOdd` are sampled at frame start; changing them during a frame does not alter that frame.
- R5: A frame starts only while `uartEn`=1 and `txEn`=1; clearing either during a frame lets the frame complete, and no further frame starts until both are high again.
- R6: A one-cycle `breakSet` pulse sets `breakPending`; a break frame is sent (low for positions 0..N, high for the stop bit), and it has priority over a waiting data word.
- R7: `txe` is 1 after reset, goes to 0 on `dataWrite`, and returns to 1 when the holding register is moved into the shift register at frame start.
- R8: `tc` is 1 after reset, goes to 0 on `dataWrite` or at any frame start, and goes to 1 at the end of a stop bit when no data word and no break are waiting.
- R9: `irq` equals (`txeIe` AND `txe`) OR (`tcIe` AND `tc`).
- R10: `txOut` is high whenever no frame is in progress, including after reset and while disabled.
- R11: `breakPending` stays 1 through the break frame's start and data positions and is 0 during its stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divisor | input | 16 | Clock cycles per oversampling tick, minus one |
| uartEn | input | 1 | Global enable, applied at frame boundaries |
| txEn | input | 1 | Transmitter enable |
| wordNine | input | 1 | 1: nine data positions, 0: eight |
| parityEn | input | 1 | Parity bit replaces data MSB |
| parityOdd | input | 1 | 1: odd parity, 0: even parity |
| txeIe | input | 1 | Interrupt enable for holding-register-empty |
| tcIe | input | 1 | Interrupt enable for transmit-complete |
| dataIn | input | 9 | Data word to load |
| dataWrite | input | 1 | One-cycle strobe writing `dataIn` to the holding register |
| breakSet | input | 1 | One-cycle strobe requesting a break frame |
| txOut | output | 1 | Serial transmit line |
| txe | output | 1 | Holding register empty |
| tc | output | 1 | Transmission complete |
| breakPending | output | 1 | Break request not yet reaching its stop bit |
| irq | output | 1 | Combined enabled status interrupt |

## Verification
The assertions assume that `divisor` stays constant while a frame is on the line, that `dataWrite` is issued only while `txe` is high or the transmitter is idle, and that `dataWrite` and `breakSet` are single-cycle strobes. The bench changes the divisor only between frames, once the line is back at idle. It writes a word only after the previous one has been taken, and it drives each strobe for one cycle at a falling edge. Configuration is randomised only between frames, except for the deliberate changes made mid-frame that test sampling at frame start.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic load;     // move a new frame into the shift register
    logic asBreak;  // the frame being loaded is a break frame
    logic shift;    // advance to the next bit position
  } txStrobe_t;

endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int OVS    = 16,
  parameter int DATA_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             uartEn,
  input  logic             txEn,
  input  logic             wordNine,
  input  logic             dataWrite,
  input  logic             breakSet,
  output txStrobe_t        strobe,
  output logic             busy,
  output logic             txe,
  output logic             tc,
  output logic             breakPending
);

  localparam int FRAME_W = DATA_W + 2;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int TICK_W  = $clog2(OVS);

  logic [DIV_W-1:0]  divCnt;
  logic [TICK_W-1:0] tickCnt;
  logic [IDX_W-1:0]  bitIdx;
  logic [IDX_W-1:0]  lastIdx;
  logic              frameNine;
  logic              frameBreak;
  logic              breakFlag;
  logic              startNow;
  logic              tick;
  logic              bitEnd;
  logic              frameEnd;

  assign lastIdx  = frameNine ? IDX_W'(FRAME_W - 1) : IDX_W'(FRAME_W - 2);
  assign startNow = !busy && uartEn && txEn && (breakFlag || !txe);
  assign tick     = busy && (divCnt == divisor);
  assign bitEnd   = tick && (tickCnt == TICK_W'(OVS - 1));
  assign frameEnd = bitEnd && (bitIdx == lastIdx);

  assign strobe.load    = startNow;
  assign strobe.asBreak = breakFlag;
  assign strobe.shift   = bitEnd && !frameEnd;

  assign breakPending = breakFlag;

  // Bit timing: divider, oversampling tick counter, bit position.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      divCnt     <= '0;
      tickCnt    <= '0;
      bitIdx     <= '0;
      frameNine  <= 1'b0;
      frameBreak <= 1'b0;
    end else if (startNow) begin
      busy       <= 1'b1;
      divCnt     <= '0;
      tickCnt    <= '0;
      bitIdx     <= '0;
      frameNine  <= wordNine;
      frameBreak <= breakFlag;
    end else if (busy) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (bitEnd)    tickCnt <= '0;
      else if (tick) tickCnt <= tickCnt + 1'b1;
      if (frameEnd)    busy   <= 1'b0;
      else if (bitEnd) bitIdx <= bitIdx + 1'b1;
    end
  end

  // Status and break request flags.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txe       <= 1'b1;
      tc        <= 1'b1;
      breakFlag <= 1'b0;
    end else begin
      if (dataWrite)                  txe <= 1'b0;
      else if (startNow && !breakFlag) txe <= 1'b1;

      if (dataWrite || startNow)                  tc <= 1'b0;
      else if (frameEnd && txe && !breakFlag)     tc <= 1'b1;

      if (breakSet) breakFlag <= 1'b1;
      else if (bitEnd && frameBreak && (bitIdx == lastIdx - 1'b1)) breakFlag <= 1'b0;
    end
  end

  // R11: the break request clears only as the break frame enters its stop bit
  a_r11_break_clear_at_stop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(breakFlag) |-> (busy && frameBreak && bitIdx == lastIdx));

  // R7: holding register reports empty only after a data frame was loaded
  a_r7_txe_set_on_load: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txe) |-> $past(startNow && !breakFlag));

  // R8: complete only rises when a stop bit ends with nothing waiting
  a_r8_tc_set_at_stop_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tc) |-> ($past(frameEnd) && $past(txe)));

  // R6: a pending break with the transmitter enabled and idle starts next
  a_r6_break_starts: assert property (@(posedge clk) disable iff (!rstN)
    (breakFlag && !busy && uartEn && txEn) |=> (busy && frameBreak));

  // R1: the bit position never runs past the stop bit of the frame length
  a_r1_idx_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitIdx <= lastIdx));

endmodule

// File: rtl/uart_tx_dp.sv
module uart_tx_dp
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              dataWrite,
  input  logic              wordNine,
  input  logic              parityEn,
  input  logic              parityOdd,
  output logic              txOut
);

  localparam int FRAME_W = DATA_W + 2;

  logic [DATA_W-1:0]  holdReg;
  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] dataFrame;
  logic [FRAME_W-1:0] breakFrame;
  logic               parityAcc;
  int                 topPos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          holdReg <= '0;
    else if (dataWrite) holdReg <= dataIn;
  end

  // Frame assembly; word length and parity are taken at load time.
  always_comb begin
    topPos    = wordNine ? DATA_W : DATA_W - 1;
    parityAcc = parityOdd;
    for (int i = 0; i < DATA_W - 1; i++)
      if (i < topPos - 1) parityAcc = parityAcc ^ holdReg[i];
    dataFrame = '1;
    dataFrame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < topPos) dataFrame[i + 1] = holdReg[i];
    if (parityEn) dataFrame[topPos] = parityAcc;
  end

  for (genvar g = 0; g < FRAME_W; g++) begin : gBreak
    assign breakFrame[g] = (g > topPos);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '1;
    else if (strobe.load)  shiftReg <= strobe.asBreak ? breakFrame : dataFrame;
    else if (strobe.shift) shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
  end

  assign txOut = shiftReg[0];

  // R1: every frame begins with a low start bit right after loading
  a_r1_start_low: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !txOut);

endmodule

// File: rtl/uart_break_tx.sv
module uart_break_tx
  import uart_tx_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int OVS    = 16,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              uartEn,
  input  logic              txEn,
  input  logic              wordNine,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              txeIe,
  input  logic              tcIe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              dataWrite,
  input  logic              breakSet,
  output logic              txOut,
  output logic              txe,
  output logic              tc,
  output logic              breakPending,
  output logic              irq
);

  txStrobe_t strobe;
  logic      busy;

  uart_tx_ctrl #(.DIV_W(DIV_W), .OVS(OVS), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .divisor(divisor), .uartEn(uartEn), .txEn(txEn),
    .wordNine(wordNine), .dataWrite(dataWrite), .breakSet(breakSet),
    .strobe(strobe), .busy(busy), .txe(txe), .tc(tc), .breakPending(breakPending)
  );

  uart_tx_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn), .dataWrite(dataWrite),
    .wordNine(wordNine), .parityEn(parityEn), .parityOdd(parityOdd), .txOut(txOut)
  );

  assign irq = (txeIe && txe) || (tcIe && tc);

  // R10: the line rests high between frames
  a_r10_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txOut);

  // R5: no frame begins while either enable is low
  a_r5_no_start_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(uartEn && txEn)) |=> !busy);

endmodule

// File: tb/tb_uart_break_tx.sv
module tb_uart_break_tx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [15:0] divisor = 16'd0;
  logic       uartEn = 1'b1, txEn = 1'b1;
  logic       wordNine = 1'b0, parityEn = 1'b0, parityOdd = 1'b0;
  logic       txeIe = 1'b0, tcIe = 1'b0;
  logic [8:0] dataIn = '0;
  logic       dataWrite = 1'b0, breakSet = 1'b0;
  logic       txOut, txe, tc, breakPending, irq;

  int checks = 0;
  int errors = 0;
  int bt = 16;
  int cyc = 0;

  uart_break_tx dut (
    .clk(clk), .rstN(rstN), .divisor(divisor), .uartEn(uartEn), .txEn(txEn),
    .wordNine(wordNine), .parityEn(parityEn), .parityOdd(parityOdd),
    .txeIe(txeIe), .tcIe(tcIe), .dataIn(dataIn), .dataWrite(dataWrite),
    .breakSet(breakSet), .txOut(txOut), .txe(txe), .tc(tc),
    .breakPending(breakPending), .irq(irq)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [10:0] expFrame(logic [8:0] d, bit nine, bit pe, bit odd, bit brk);
    logic [10:0] f;
    int nd;
    logic p;
    f  = '1;
    nd = nine ? 9 : 8;
    if (brk) begin
      for (int i = 0; i <= nd; i++) f[i] = 1'b0;
      return f;
    end
    f[0] = 1'b0;
    for (int i = 0; i < nd; i++) f[i + 1] = d[i];
    if (pe) begin
      p = odd;
      for (int i = 0; i < nd - 1; i++) p = p ^ d[i];
      f[nd] = p;
    end
    return f;
  endfunction

  task automatic setDiv(input int d);
    divisor = 16'(d);
    bt = 16 * (d + 1);
  endtask

  // Receives one frame, sampling mid-bit; optional mid-frame disturbances.
  task automatic recvFrame(input logic [10:0] ev, input int nb, input bit flip,
                           input bit dropEn, input bit brk, input bit endChk, input string req);
    int waitN = 0;
    while (txOut !== 1'b0 && waitN < 4000) begin
      @(negedge clk);
      waitN++;
    end
    if (waitN >= 4000) begin
      chk(1'b0, {req, " frame start"}, 1, 0);
      return;
    end
    repeat (bt / 2) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      if (k > 0) repeat (bt) @(negedge clk);
      chk(txOut === ev[k], $sformatf("%s bit%0d", req, k), int'(txOut), int'(ev[k]));
      if (brk && k == 0) chk(breakPending === 1'b1, "R11 pending in break start", int'(breakPending), 1);
      if (brk && k == nb - 1) chk(breakPending === 1'b0, "R11 cleared in stop", int'(breakPending), 0);
      if (flip && k == 0) begin
        parityOdd = ~parityOdd;
        parityEn  = ~parityEn;
        wordNine  = ~wordNine;
      end
      if (dropEn && k == 1) uartEn = 1'b0;
    end
    if (endChk) begin
      repeat (bt / 2 + 2) @(negedge clk);
      chk(txOut === 1'b1, "R10 idle after frame", int'(txOut), 1);
      chk(tc === 1'b1, "R8 tc after stop", int'(tc), 1);
      chk(txe === 1'b1, "R7 txe after frame", int'(txe), 1);
      chk(irq === (txeIe | tcIe), "R9 irq idle", int'(irq), int'(txeIe | tcIe));
    end
  endtask

  task automatic writeWord(input logic [8:0] d);
    @(negedge clk);
    dataIn    = d;
    dataWrite = 1'b1;
    @(negedge clk);
    dataWrite = 1'b0;
    chk(txe === 1'b0, "R7 txe cleared by write", int'(txe), 0);
    chk(tc === 1'b0, "R8 tc cleared by write", int'(tc), 0);
    chk(irq === 1'b0, "R9 irq with flags low", int'(irq), 0);
  endtask

  task automatic sendFrame(input logic [8:0] d, input bit flip, input string req);
    logic [10:0] ev;
    int nb;
    ev = expFrame(d, wordNine, parityEn, parityOdd, 1'b0);
    nb = wordNine ? 11 : 10;
    writeWord(d);
    recvFrame(ev, nb, flip, 1'b0, 1'b0, 1'b1, req);
  endtask

  task automatic quietWait(input string req);
    int bad = 0;
    repeat (bt * 24) begin
      @(negedge clk);
      if (txOut !== 1'b1) bad++;
    end
    chk(bad == 0, req, bad, 0);
    chk(txe === 1'b0, "R5 word still held", int'(txe), 0);
  endtask

  initial begin
    int lowCnt;
    logic [8:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state
    chk(txOut === 1'b1, "R10 reset line high", int'(txOut), 1);
    chk(txe === 1'b1, "R7 reset txe", int'(txe), 1);
    chk(tc === 1'b1, "R8 reset tc", int'(tc), 1);
    chk(breakPending === 1'b0, "R6 reset no break", int'(breakPending), 0);
    chk(irq === 1'b0, "R9 reset irq masked", int'(irq), 0);
    txeIe = 1'b1;
    #1 chk(irq === 1'b1, "R9 irq from txe", int'(irq), 1);
    txeIe = 1'b0;

    // R2: start bit length with divisor 2
    setDiv(2);
    writeWord(9'h001);
    lowCnt = 0;
    while (txOut !== 1'b0) @(negedge clk);
    while (txOut === 1'b0) begin
      lowCnt++;
      @(negedge clk);
    end
    chk(lowCnt == bt, "R2 bit time", lowCnt, bt);
    repeat (bt * 11) @(negedge clk);

    // Directed parity corners: R1 / R3
    setDiv(0);
    wordNine = 0; parityEn = 1; parityOdd = 0;
    sendFrame(9'h07F, 1'b0, "R3 even 8-bit");
    parityOdd = 1;
    sendFrame(9'h000, 1'b0, "R3 odd 8-bit");
    wordNine = 1; parityEn = 0;
    sendFrame(9'h1A5, 1'b0, "R1 nine bits");

    // Random frames, some with mid-frame config flips (R4)
    for (int i = 0; i < 24; i++) begin
      setDiv($urandom % 3);
      wordNine  = 1'($urandom);
      parityEn  = 1'($urandom);
      parityOdd = 1'($urandom);
      txeIe     = 1'($urandom);
      tcIe      = 1'($urandom);
      d = 9'($urandom);
      sendFrame(d, (i % 3) == 0, (i % 3) == 0 ? "R4 flip mid-frame" : "R1 R3 random");
    end

    // R6: break alone
    setDiv(1);
    wordNine = 0;
    @(negedge clk); breakSet = 1'b1;
    @(negedge clk); breakSet = 1'b0;
    chk(breakPending === 1'b1, "R6 break set", int'(breakPending), 1);
    recvFrame(expFrame(9'h0, 0, 0, 0, 1), 10, 0, 0, 1, 1, "R6 break 8");

    // R6: break beats a waiting word
    wordNine = 1; parityEn = 0;
    @(negedge clk); dataIn = 9'h155; dataWrite = 1'b1; breakSet = 1'b1;
    @(negedge clk); dataWrite = 1'b0; breakSet = 1'b0;
    recvFrame(expFrame(9'h0, 1, 0, 0, 1), 11, 0, 0, 1, 0, "R6 break first");
    recvFrame(expFrame(9'h155, 1, 0, 0, 0), 11, 0, 0, 0, 1, "R6 word after break");

    // R5: disabled from idle
    uartEn = 1'b0;
    wordNine = 0;
    writeWord(9'h0C3);
    quietWait("R5 no frame while disabled");
    uartEn = 1'b1;
    recvFrame(expFrame(9'h0C3, 0, 0, 0, 0), 10, 0, 0, 0, 1, "R5 frame after enable");

    // R5: global enable dropped mid-frame lets the frame finish
    writeWord(9'h03C);
    recvFrame(expFrame(9'h03C, 0, 0, 0, 0), 10, 0, 1, 0, 1, "R5 finish after disable");
    writeWord(9'h0AA);
    quietWait("R5 stays stopped");
    uartEn = 1'b1;
    txEn = 1'b0;
    quietWait("R5 transmitter enable low");
    txEn = 1'b1;
    recvFrame(expFrame(9'h0AA, 0, 0, 0, 0), 10, 0, 0, 0, 1, "R5 resume");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule